// File: doc/BRIEF.md
# Busy-Triggered Serial ADC Frame Reader

This block collects one sample word from a serial analog-to-digital converter each time a conversion completes. The converter's busy line is brought into the system clock domain and watched for its falling edge, which signals that a fresh result is ready. On that edge the block produces one burst of serial clock pulses. It shifts in one data bit per pulse and then hands the complete word to the rest of the chip, together with a single-cycle valid strobe.

The serial clock is an ordinary register output toggled by the system clock, so no gated clock exists. It idles low between bursts. Each burst has a fixed length, and a new conversion edge that arrives while a burst is running is dropped. The block treats busy only as a sampled level. Every state change happens on the rising edge of the system clock.

Top module: `adc_burst_reader`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block is forced idle at that edge: sclk_o is low, valid_o is low and data_o is all zeros. This holds even when a burst is in progress, and no burst follows the reset unless a new busy falling edge arrives.
- R2: A burst starts only after a high-to-low transition of busy_i, seen through a two-stage synchronizer, while no burst is running. While busy_i is high, or is held low after a burst, sclk_o stays low.
- R3: Each burst has exactly FRAME_BITS (default 32) rising edges of sclk_o.
- R4: During a burst, sclk_o is high for one system clock and low for one system clock, giving a serial period of two system clocks. From the first rising edge of sclk_o to the valid_o pulse is 2*FRAME_BITS-1 system clocks.
- R5: sdi_i is sampled at the system-clock edge that raises sclk_o. The first bit sampled becomes data_o bit FRAME_BITS-1 (MSB first), and the last becomes bit 0.
- R6: After the last rising edge, valid_o is high for exactly one system clock, with sclk_o low, and data_o carries the new word in that cycle. data_o changes only in a valid_o cycle or at reset, and otherwise holds its value.
- R7: A busy_i falling edge during a running burst is ignored and not queued. The burst still ends after FRAME_BITS pulses, and no second burst follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| busy_i | input | 1 | Converter busy level, asynchronous to clk |
| sdi_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| data_o | output | FRAME_BITS | Last completed sample word |
| valid_o | output | 1 | One-cycle strobe marking a new word on data_o |

## Verification
The bench uses the default parameters: FRAME_BITS of 32 and a two-stage synchronizer. At these values, full-width words are reachable, so corner patterns such as all ones, alternating bits and a lone MSB show bit ordering across the whole register. The default values also exercise the counter's terminal value at 31 and the 63-cycle burst length. A behavioural converter model changes its data on the falling edge of sclk_o. The bench therefore checks correct sampling at the rising edge, as well as busy glitches during a burst and a reset that interrupts a burst.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

    typedef struct packed {
        logic sclk;     // registered serial clock level
        logic capture;  // this edge raises sclk: sample data
        logic finish;   // this edge ends the burst: publish word
    } sclk_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned bits);
        return (bits > 1) ? $clog2(bits) : 1;
    endfunction

endpackage

// File: rtl/adc_rd_busy_sync.sv
module adc_rd_busy_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= busy_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], busy_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign fall_o = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/adc_rd_burst_ctl.sv
module adc_rd_burst_ctl
    import adc_rd_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    output sclk_ctl_t ctl_o
);
    localparam int unsigned CW = cnt_width(FRAME_BITS);
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

    burst_state_e  state_q;
    logic          sclk_q;
    logic          last_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sclk_q  <= 1'b0;
            last_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= 1'b0;
                    if (start_i) begin
                        state_q <= ST_BURST;
                        cnt_q   <= '0;
                        last_q  <= 1'b0;
                    end
                end
                default: begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        if (cnt_q == LAST_IDX) last_q <= 1'b1;
                        else                   cnt_q  <= cnt_q + 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (last_q) begin
                            state_q <= ST_IDLE;
                            last_q  <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        ctl_o.sclk    = sclk_q;
        ctl_o.capture = (state_q == ST_BURST) && !sclk_q;
        ctl_o.finish  = (state_q == ST_BURST) && sclk_q && last_q;
    end
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter
    import adc_rd_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  sclk_ctl_t             ctl_i,
    input  logic                  sdi_i,
    output logic [FRAME_BITS-1:0] data_o,
    output logic                  valid_o
);
    logic [FRAME_BITS-1:0] shift_q;

    generate
        if (FRAME_BITS == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n)             shift_q <= '0;
                else if (ctl_i.capture) shift_q <= sdi_i;
            end
        end else begin : g_wide
            always_ff @(posedge clk) begin
                if (!rst_n)             shift_q <= '0;
                else if (ctl_i.capture) shift_q <= {shift_q[FRAME_BITS-2:0], sdi_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= ctl_i.finish;
            if (ctl_i.finish) data_o <= shift_q;
        end
    end
endmodule

// File: rtl/adc_burst_reader.sv
module adc_burst_reader
    import adc_rd_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  busy_i,
    input  logic                  sdi_i,
    output logic                  sclk_o,
    output logic [FRAME_BITS-1:0] data_o,
    output logic                  valid_o
);
    logic      busy_fall;
    sclk_ctl_t ctl;

    adc_rd_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_i),
        .fall_o (busy_fall)
    );

    adc_rd_burst_ctl #(.FRAME_BITS(FRAME_BITS)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (busy_fall),
        .ctl_o   (ctl)
    );

    adc_rd_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_i   (ctl),
        .sdi_i   (sdi_i),
        .data_o  (data_o),
        .valid_o (valid_o)
    );

    assign sclk_o = ctl.sclk;
endmodule

// File: rtl/adc_burst_reader_chk.sv
module adc_burst_reader_chk #(
    parameter int unsigned FRAME_BITS = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sclk_o,
    input logic [FRAME_BITS-1:0] data_o,
    input logic                  valid_o
);
    logic        sclk_d;
    int unsigned rises;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            rises  <= 0;
        end else begin
            sclk_d <= sclk_o;
            if (valid_o)                rises <= 0;
            else if (sclk_o && !sclk_d) rises <= rises + 1;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!sclk_o && !valid_o && data_o == '0));

    a_r3_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> rises == FRAME_BITS);

    a_r7_no_extra_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rises == FRAME_BITS) |-> !(sclk_o && !sclk_d));

    a_r4_high_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |=> $fell(sclk_o));

    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r6_valid_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !sclk_o);

    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> valid_o);
endmodule

bind adc_burst_reader adc_burst_reader_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_o  (sclk_o),
    .data_o  (data_o),
    .valid_o (valid_o)
);

// File: tb/tb_adc_burst_reader.sv
module tb_adc_burst_reader;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         busy = 1'b0;
    logic         sdi;
    logic         sclk;
    logic [W-1:0] data;
    logic         valid;

    always #10 clk = ~clk;

    adc_burst_reader #(.FRAME_BITS(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .sdi_i(sdi),
        .sclk_o(sclk), .data_o(data), .valid_o(valid)
    );

    // converter model: data changes on falling sclk, MSB first
    logic [W-1:0] adc_word = '0;
    int           adc_idx = 0;
    assign sdi = (adc_idx < W) ? adc_word[W-1-adc_idx] : 1'b0;
    always @(negedge sclk) adc_idx = adc_idx + 1;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // monitor at falling clk edge
    int cyc = 0;
    int rises = 0;
    int vcount = 0;
    int first_rise_cyc = -1;
    int last_valid_cyc = 0;
    int rises_at_valid = 0;
    int wide_high = 0;
    int double_valid = 0;
    logic sclk_prev = 1'b0;
    logic valid_prev = 1'b0;
    logic [W-1:0] valid_word = '0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (sclk && !sclk_prev) begin
                rises = rises + 1;
                if (first_rise_cyc < 0) first_rise_cyc = cyc;
            end
            if (sclk && sclk_prev) wide_high = wide_high + 1;
            if (valid) begin
                vcount = vcount + 1;
                valid_word = data;
                last_valid_cyc = cyc;
                rises_at_valid = rises;
                if (valid_prev) double_valid = double_valid + 1;
            end
        end
        sclk_prev = sclk;
        valid_prev = valid;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // bench reference: reassemble the word in the order the model sends bits
    function automatic logic [W-1:0] expect_word(input logic [W-1:0] w);
        logic [W-1:0] r = '0;
        for (int i = 0; i < W; i++) r = {r[W-2:0], w[W-1-i]};
        return r;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_counters();
        rises = 0;
        first_rise_cyc = -1;
        wide_high = 0;
        double_valid = 0;
    endtask

    // runs one conversion; glitch adds a busy pulse mid-burst
    task automatic frame(input logic [W-1:0] w, input bit glitch);
        int v0;
        int r0;
        int waited;
        adc_word = w;
        adc_idx = 0;
        reset_counters();
        v0 = vcount;
        busy = 1'b1;
        cycles(6);
        chk(rises == 0 && !sclk, "R2", "sclk idle while busy high", W'(rises), 0);
        busy = 1'b0;
        if (glitch) begin
            cycles(20);
            busy = 1'b1;
            cycles(4);
            busy = 1'b0;
        end
        waited = 0;
        while (vcount == v0 && waited < 300) begin
            cycles(1);
            waited++;
        end
        chk(vcount == v0 + 1, "R2", "burst after busy fall", W'(vcount - v0), 1);
        chk(valid_word == expect_word(w), "R5", "captured word", valid_word, expect_word(w));
        chk(rises_at_valid == W, "R3", "pulses per burst", W'(rises_at_valid), W);
        chk(last_valid_cyc - first_rise_cyc == 2*W-1 && wide_high == 0, "R4",
            "burst length", W'(last_valid_cyc - first_rise_cyc), 2*W-1);
        cycles(1);
        chk(!valid, "R6", "valid one cycle", W'(valid), 0);
        cycles(glitch ? 120 : 20);
        chk(data == expect_word(w) && double_valid == 0, "R6", "data held", data, expect_word(w));
        if (glitch) begin
            chk(vcount == v0 + 1 && rises == W, "R7", "mid-burst fall ignored",
                W'(rises), W);
        end else begin
            chk(rises == W, "R2", "no restart while busy low", W'(rises), W);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cycles(3);
        chk(!sclk && !valid && data == '0, "R1", "reset state", data, 0);
        rst_n = 1'b1;
        cycles(10);
        chk(!sclk && vcount == 0, "R2", "no burst without busy edge", W'(vcount), 0);

        frame(32'hFFFF_FFFF, 0);
        frame(32'h0000_0000, 0);
        frame(32'hAAAA_5555, 0);
        frame(32'h8000_0000, 0);
        frame(32'h0000_0001, 0);
        frame(32'hDEAD_BEEF, 1);
        for (int i = 0; i < 20; i++) frame(W'($urandom), (i % 5) == 2);

        // reset in the middle of a burst
        adc_word = 32'h1234_5678;
        adc_idx = 0;
        reset_counters();
        busy = 1'b1;
        cycles(5);
        busy = 1'b0;
        cycles(30);
        rst_n = 1'b0;
        cycles(2);
        chk(!sclk && !valid && data == '0, "R1", "reset mid-burst", data, 0);
        rst_n = 1'b1;
        reset_counters();
        cycles(100);
        chk(rises == 0 && !valid, "R1", "no burst after reset", W'(rises), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule